// File: doc/BRIEF.md
# Interrupt Priority and Autovector Unit

This unit sits on the processor side of the interrupt path. Three active-low request lines carry a priority level from 0 to 7. The unit passes that level through a filter that accepts a value only after it reads the same on consecutive clocks. It then compares the filtered level with a 3-bit priority mask. When the level is above the mask and no acknowledge is in progress, the unit holds off the instruction sequencer. It then starts an acknowledge bus cycle, with the address taken from the top sixteen bytes of the address space.

The external logic answers the acknowledge by pulling the valid-peripheral-address line low. On that reply, the unit computes an autovector number from the accepted level. It does not read a vector from the data bus. It hands the sequencer both the vector number and the byte address of the handler pointer, and it raises the mask to the accepted level. Software writes the mask through a simple write port, and the current mask is always visible.

Top module: `irq_autovec_unit`

## Requirements
- R1: The requested level is the bitwise inverse of `ipl_n`: `3'b111` means level 0, which is never accepted, and `3'b000` means level 7.
- R2: A new line value takes part in arbitration only once it has been seen on two consecutive clock edges. A value driven before edge k can start an acknowledge at edge k+3 at the earliest. A value present for a single edge is discarded.
- R3: A filtered level that is equal to or lower than `mask_q` starts no acknowledge and leaves the mask unchanged.
- R4: A filtered level above `mask_q`, while the unit is idle, starts an acknowledge on the next edge. `seq_hold` is high from the first acknowledge cycle until the vector cycle ends.
- R5: During an acknowledge, `ack_addr` is `0xFFFFF0` with the accepted level in bits 3..1 and bit 0 set. It stays at that value for as long as `vpa_n` is high, even if the request lines change.
- R6: A low `vpa_n` on an acknowledge cycle produces a one-cycle `vec_valid` on the next cycle, with `vec_num` = 24 + accepted level.
- R7: `vec_ptr` equals `vec_num` × 4 and fits within the lowest 1 KB.
- R8: When the vector is delivered, `mask_q` takes the accepted level. This update wins over a software mask write in the same cycle.
- R9: Reset leaves `mask_q` = 7 and no acknowledge active. Outside the delivery cycle, `mask_wr_en` loads `mask_wr_data` on the next edge.
- R10: A change of the request lines during an acknowledge does not alter the vector being delivered. A higher level that is still pending afterwards starts its own acknowledge.
- R11: `vpa_n` is ignored when no acknowledge is active: no vector is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| ipl_n | input | 3 | Active-low encoded interrupt request level |
| mask_wr_en | input | 1 | Software write strobe for the priority mask |
| mask_wr_data | input | 3 | New mask value |
| vpa_n | input | 1 | Active-low valid-peripheral-address reply |
| mask_q | output | 3 | Current priority mask |
| seq_hold | output | 1 | Suspends normal sequencing while an interrupt is taken |
| ack_active | output | 1 | Acknowledge bus cycle in progress |
| ack_addr | output | 24 | Acknowledge address |
| vec_valid | output | 1 | One-cycle strobe: vector outputs are valid |
| vec_num | output | 8 | Autovector number |
| vec_ptr | output | 10 | Byte address of the handler pointer |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, a filter depth of two, an autovector base of 24 and an 8-bit vector. With these values every level 0..7 maps to a distinct, checkable acknowledge address and vector, all inside the lowest kilobyte. The two-sample filter makes the one-cycle glitch and the exact three-edge acceptance latency reachable from the pins. A responder with a programmable reply delay stretches the acknowledge, so the bench can move the request lines mid-cycle and collide a software mask write with the vector delivery.

// File: rtl/irq_av_pkg.sv
package irq_av_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_VEC  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter #(
  parameter int LVL_W = 3,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ipl_n,
  output logic [LVL_W-1:0] lvl_q
);
  localparam int LAST = DEPTH - 1;

  logic [LVL_W-1:0] smp_q [DEPTH];
  logic [LVL_W-1:0] smp_d [DEPTH];
  logic             agree;
  logic             lvl_en;

  // sample chain next state
  always_comb begin
    smp_d[0] = ~ipl_n;
    for (int i = 1; i < DEPTH; i++) smp_d[i] = smp_q[i-1];
  end

  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < DEPTH; i++)
      if (smp_q[i] != smp_q[0]) agree = 1'b0;
  end

  assign lvl_en = agree && (lvl_q != smp_q[LAST]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) smp_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) smp_q[i] <= smp_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= smp_q[LAST];
  end

  p_filter_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(agree));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_av_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             vpa_n,
  input  logic             mask_wr_en,
  input  logic [LVL_W-1:0] mask_wr_data,
  output ack_state_e       state_q,
  output logic [LVL_W-1:0] acc_lvl_q,
  output logic [LVL_W-1:0] mask_q
);
  localparam logic [LVL_W-1:0] MASK_RST = '1;

  ack_state_e       state_d;
  logic             accept;
  logic             deliver;
  logic [LVL_W-1:0] mask_d;
  logic             mask_en;

  assign accept  = (state_q == ST_IDLE) && (lvl > mask_q);
  assign deliver = (state_q == ST_ACK) && !vpa_n;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)  state_d = ST_ACK;
      ST_ACK:  if (deliver) state_d = ST_VEC;
      ST_VEC:               state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mask_en = deliver || mask_wr_en;
    mask_d  = deliver ? acc_lvl_q : mask_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_lvl_q <= '0;
    else if (accept) acc_lvl_q <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (mask_en) mask_q <= mask_d;
  end

  p_ignore_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && lvl <= mask_q) |=> (state_q != ST_ACK));
  p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && lvl > mask_q) |=> (state_q == ST_ACK));
  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && vpa_n) |=> (state_q == ST_ACK && $stable(acc_lvl_q)));
  p_mask_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && !vpa_n) |=> (state_q == ST_VEC && mask_q == $past(acc_lvl_q)));
  p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && !(state_q == ST_ACK && !vpa_n)) |=> (mask_q == $past(mask_wr_data)));
  p_vpa_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_VEC));
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 24,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24
) (
  input  logic [LVL_W-1:0]   lvl,
  output logic [ADDR_W-1:0]  ack_addr,
  output logic [VEC_W-1:0]   vec_num,
  output logic [VEC_W+1:0]   vec_ptr
);
  localparam int               HI_W   = ADDR_W - LVL_W - 1;
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

  // acknowledge address: all ones above the level field, strobe bit 0 set
  generate
    if (HI_W > 0) begin : g_hi
      assign ack_addr = {{HI_W{1'b1}}, lvl, 1'b1};
    end else begin : g_flat
      assign ack_addr = ADDR_W'({lvl, 1'b1});
    end
  endgenerate

  assign vec_num = BASE_V + VEC_W'(lvl);
  assign vec_ptr = {vec_num, 2'b00};
endmodule

// File: rtl/irq_autovec_unit.sv
module irq_autovec_unit
  import irq_av_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 24,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24,
  parameter int FILT_DEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  ipl_n,
  input  logic              mask_wr_en,
  input  logic [LVL_W-1:0]  mask_wr_data,
  input  logic              vpa_n,
  output logic [LVL_W-1:0]  mask_q,
  output logic              seq_hold,
  output logic              ack_active,
  output logic [ADDR_W-1:0] ack_addr,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic [VEC_W+1:0]  vec_ptr
);
  localparam int PTR_W = VEC_W + 2;

  logic [LVL_W-1:0] lvl_f;
  logic [LVL_W-1:0] acc_lvl;
  ack_state_e       state;

  irq_level_filter #(.LVL_W(LVL_W), .DEPTH(FILT_DEP)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .ipl_n (ipl_n),
    .lvl_q (lvl_f)
  );

  irq_ack_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl          (lvl_f),
    .vpa_n        (vpa_n),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .state_q      (state),
    .acc_lvl_q    (acc_lvl),
    .mask_q       (mask_q)
  );

  irq_vector_gen #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vgen (
    .lvl      (acc_lvl),
    .ack_addr (ack_addr),
    .vec_num  (vec_num),
    .vec_ptr  (vec_ptr)
  );

  assign ack_active = (state == ST_ACK);
  assign vec_valid  = (state == ST_VEC);
  assign seq_hold   = (state != ST_IDLE);

  p_ack_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> (&ack_addr[ADDR_W-1:4] && ack_addr[0]));
  p_vec_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_num == VEC_W'(VEC_BASE) + VEC_W'(mask_q)));
  p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  p_ptr_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_ptr[PTR_W-1:2] == vec_num && vec_ptr[1:0] == 2'b00));
  p_hold_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active || vec_valid) |-> seq_hold);
endmodule

// File: tb/irq_autovec_unit_bench.sv
module irq_autovec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ipl_n;
  logic        drv_we;
  logic [2:0]  drv_data;
  logic        clash_en, clash_we;
  logic        resp_vpa_n, idle_vpa;
  logic        mask_wr_en;
  logic [2:0]  mask_wr_data;
  logic        vpa_n;
  logic [2:0]  mask_q;
  logic        seq_hold, ack_active, vec_valid;
  logic [23:0] ack_addr;
  logic [7:0]  vec_num;
  logic [9:0]  vec_ptr;

  int checks = 0, fails = 0;
  int ack_cycles = 0, vec_seen = 0;
  int vpa_delay = 0;
  int wait_cnt = 0;
  logic [2:0] exp_q[$];

  always #5 clk = ~clk;

  assign mask_wr_en   = drv_we | clash_we;
  assign mask_wr_data = clash_we ? 3'd0 : drv_data;
  assign vpa_n        = resp_vpa_n & ~idle_vpa;

  irq_autovec_unit u_irq_autovec_unit (
    .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .vpa_n(vpa_n),
    .mask_q(mask_q), .seq_hold(seq_hold), .ack_active(ack_active),
    .ack_addr(ack_addr), .vec_valid(vec_valid), .vec_num(vec_num), .vec_ptr(vec_ptr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_addr(input logic [2:0] l);
    return 24'hFFFFF0 | (int'(l) << 1) | 1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [2:0] v);
    drv_we = 1'b1; drv_data = v;
    cyc(1);
    drv_we = 1'b0;
  endtask

  task automatic expect_irq(input logic [2:0] l);
    exp_q.push_back(l);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || seq_hold) && n < 200) begin
      cyc(1); n++;
    end
    chk(exp_q.size() == 0, req, "pending vectors", exp_q.size(), 0);
  endtask

  // vpa responder: replies after vpa_delay acknowledge cycles
  always @(negedge clk) begin
    if (ack_active) begin
      if (wait_cnt >= vpa_delay) begin
        resp_vpa_n <= 1'b0;
        clash_we   <= clash_en;
      end else begin
        resp_vpa_n <= 1'b1;
      end
      wait_cnt = wait_cnt + 1;
    end else begin
      resp_vpa_n <= 1'b1;
      clash_we   <= 1'b0;
      wait_cnt = 0;
    end
  end

  // monitor: compares the design's output against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_active) begin
        ack_cycles++;
        chk(seq_hold, "R4", "seq_hold during ack", int'(seq_hold), 1);
        if (exp_q.size() == 0)
          chk(1'b0, "R3", "unexpected ack", int'(ack_addr), 0);
        else
          chk(int'(ack_addr) == exp_addr(exp_q[0]), "R5", "ack_addr",
              int'(ack_addr), exp_addr(exp_q[0]));
      end
      if (vec_valid) begin
        vec_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected vector", int'(vec_num), 0);
        end else begin
          logic [2:0] l;
          l = exp_q.pop_front();
          chk(int'(vec_num) == 24 + int'(l), "R6", "vec_num", int'(vec_num), 24 + int'(l));
          chk(int'(vec_ptr) == (24 + int'(l)) * 4, "R7", "vec_ptr", int'(vec_ptr), (24 + int'(l)) * 4);
          chk(mask_q == l, "R8", "mask after vector", int'(mask_q), int'(l));
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a0, v0;
    rst_n = 1'b0; ipl_n = 3'b111; drv_we = 1'b0; drv_data = 3'd0;
    clash_en = 1'b0; idle_vpa = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R9 reset state
    chk(mask_q == 3'd7, "R9", "reset mask", int'(mask_q), 7);
    chk(!ack_active && !vec_valid && !seq_hold, "R9", "reset idle",
        int'({ack_active, vec_valid, seq_hold}), 0);

    // R3: level 3 below reset mask 7 is ignored
    ipl_n = ~3'd3;
    cyc(10);
    chk(ack_cycles == 0, "R3", "ack under mask", ack_cycles, 0);
    chk(mask_q == 3'd7, "R3", "mask unchanged", int'(mask_q), 7);

    // R9 + R4: lowering the mask admits level 3
    expect_irq(3'd3);
    write_mask(3'd2);
    chk(mask_q == 3'd2, "R9", "mask write", int'(mask_q), 2);
    wait_done("R4");
    chk(vec_seen == 1, "R4", "vector count", vec_seen, 1);

    // R2: single-cycle glitch to level 5 is filtered
    a0 = ack_cycles;
    ipl_n = ~3'd5; cyc(1); ipl_n = ~3'd3;
    cyc(10);
    chk(ack_cycles == a0, "R2", "glitch filtered", ack_cycles - a0, 0);
    chk(mask_q == 3'd3, "R2", "mask after glitch", int'(mask_q), 3);

    // R2 latency and R10: level change during a stretched acknowledge
    vpa_delay = 4;
    expect_irq(3'd5);
    ipl_n = ~3'd5;
    cyc(3);
    chk(!ack_active, "R2", "no ack before edge k+3", int'(ack_active), 0);
    cyc(1);
    chk(ack_active, "R2", "ack at edge k+3", int'(ack_active), 1);
    ipl_n = ~3'd6;
    expect_irq(3'd6);
    wait_done("R10");
    chk(mask_q == 3'd6, "R10", "mask after second vector", int'(mask_q), 6);

    // R1: all-low lines mean level 7
    vpa_delay = 0;
    expect_irq(3'd7);
    ipl_n = 3'b000;
    wait_done("R1");
    chk(mask_q == 3'd7, "R1", "level 7 accepted", int'(mask_q), 7);

    // R3: equal level is ignored
    a0 = ack_cycles;
    cyc(8);
    chk(ack_cycles == a0, "R3", "equal level ignored", ack_cycles - a0, 0);

    // R1: all-high lines mean level 0, never accepted even with mask 0
    ipl_n = 3'b111;
    cyc(4);
    write_mask(3'd0);
    cyc(8);
    chk(ack_cycles == a0, "R1", "level 0 ignored", ack_cycles - a0, 0);

    // R8: delivery update wins over a same-cycle mask write of 0
    clash_en = 1'b1;
    expect_irq(3'd1);
    ipl_n = 3'b110;
    wait_done("R8");
    clash_en = 1'b0;
    chk(mask_q == 3'd1, "R8", "delivery beats write", int'(mask_q), 1);

    // R11: vpa while idle produces nothing
    ipl_n = 3'b111;
    cyc(4);
    v0 = vec_seen;
    idle_vpa = 1'b1;
    cyc(5);
    idle_vpa = 1'b0;
    cyc(2);
    chk(vec_seen == v0, "R11", "idle vpa ignored", vec_seen - v0, 0);
    chk(!seq_hold, "R11", "no hold", int'(seq_hold), 0);
    chk(mask_q == 3'd1, "R11", "mask kept", int'(mask_q), 1);

    finish_run();
  end
endmodule